// File: doc/BRIEF.md
# Serial Flash Command Front End: Write-Arm Latch and Status Streaming

This block sits on the slave side of a serial flash memory and watches a mode-0 SPI link. It shifts in an 8-bit opcode, most significant bit first, sampling MOSI on rising SCK edges. From that opcode it decides whether modifying commands (program, the two erase kinds, status write, sector lock and sector unlock) may go ahead. It keeps a write-arm latch that such commands need. The latch is set and cleared according to how each operation ends. A countdown timer models the internal busy period of a program or erase.

When the status-read opcode has been fully received, the block drives MISO from the next falling SCK edge. It streams a status byte, most significant bit first, and reloads a fresh copy at every byte boundary for as long as chip select stays low. A host can therefore poll the busy flag within one transaction. An active-low pause input aborts the transaction in progress. The memory array, address handling and data storage are not part of this block. SCK, MOSI, chip select and pause are taken as already synchronous to `clk`.

Top module: `sfe_cmd_front`

## Requirements
- R1: After reset `wr_armed` and `busy` are 0 and `miso_oe` is 0.
- R2: Opcode 0x06 ending on a byte boundary while not busy sets the write-arm latch. Opcode 0x04 ending on a byte boundary while not busy clears it. The latch is readable as status bit 1.
- R3: While the latch is 0, the guarded opcodes have no effect: the latch and `busy` stay 0. The guarded opcodes are 0x01 (status write), 0x02 (program), 0x20 (block erase), 0x60 (full erase), 0x36 (sector lock) and 0x39 (sector unlock).
- R4: With the latch set, opcodes 0x01, 0x36 and 0x39 clear it when chip select rises, whether the transfer ended on a byte boundary (completion) or not (abort). Opcodes 0x02, 0x20 and 0x60 also clear it at once when they end off a byte boundary.
- R5: A chip-select rise after fewer than 8 bits leaves the latch unchanged, including a rise with no bits at all.
- R6: Opcodes 0x02, 0x20 and 0x60, accepted and ending on a byte boundary, raise `busy` at the chip-select-rise edge. `busy` stays high for exactly BUSY_CYCLES clocks. The latch clears on the same edge that `busy` falls. Busy is status bit 0.
- R7: While `busy` is 1, every opcode other than 0x05 has no effect on the latch or the timer.
- R8: `pause_n` low while chip select is low aborts the transaction: MISO is released and the remaining bits are ignored. The latch clears only if a guarded opcode had been fully received and the block was not busy.
- R9: `miso_oe` stays 0 until all 8 opcode bits are in. For opcode 0x05 the status byte's bit 7 is driven from the falling SCK edge that follows the eighth rising edge.
- R10: The status byte is {6'b0, latch, busy}. It repeats while chip select stays low and is re-sampled at each byte boundary from the state held before that clock edge.
- R11: `miso_oe` is 0 whenever chip select is high. An unrecognised 8-bit opcode changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| mosi | input | 1 | Serial data in, sampled on rising SCK |
| pause_n | input | 1 | Active-low pause; aborts the open transaction |
| miso | output | 1 | Serial data out, changes on falling SCK |
| miso_oe | output | 1 | Output enable for MISO; 0 means high impedance |
| wr_armed | output | 1 | Write-arm latch state |
| busy | output | 1 | Internal program/erase in progress |

## Verification
Two events can fall on the same clock edge: the busy timer expiring, which also clears the latch, and the status shifter reloading its byte at a boundary during a poll. The bench starts a program and then waits a varying idle gap, stepping through every offset of the 32-clock byte period, before a long status read. In one of those runs the expiry lands exactly on a reload edge. The behavioural model expects the reloaded byte to carry the pre-edge state 0x03 and the next byte to read 0x00. It also counts how often the collision occurred, so the bench can confirm the case was really reached.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int OP_W  = 8;
    localparam int IDX_W = $clog2(OP_W);

    localparam logic [OP_W-1:0] OP_ARM        = 8'h06;
    localparam logic [OP_W-1:0] OP_DISARM     = 8'h04;
    localparam logic [OP_W-1:0] OP_STAT_RD    = 8'h05;
    localparam logic [OP_W-1:0] OP_STAT_WR    = 8'h01;
    localparam logic [OP_W-1:0] OP_PROG       = 8'h02;
    localparam logic [OP_W-1:0] OP_ERASE_BLK  = 8'h20;
    localparam logic [OP_W-1:0] OP_ERASE_ALL  = 8'h60;
    localparam logic [OP_W-1:0] OP_LOCK_SEC   = 8'h36;
    localparam logic [OP_W-1:0] OP_UNLOCK_SEC = 8'h39;

    localparam int ST_BUSY_BIT = 0;
    localparam int ST_ARM_BIT  = 1;

    // Opcodes that need the write-arm latch.
    function automatic logic is_guarded(input logic [OP_W-1:0] op);
        return op inside {OP_STAT_WR, OP_PROG, OP_ERASE_BLK, OP_ERASE_ALL,
                          OP_LOCK_SEC, OP_UNLOCK_SEC};
    endfunction

    // Guarded opcodes that start the internal busy period.
    function automatic logic is_timed(input logic [OP_W-1:0] op);
        return op inside {OP_PROG, OP_ERASE_BLK, OP_ERASE_ALL};
    endfunction

    typedef struct packed {
        logic              sck;
        logic              sel;
        logic [OP_W-1:0]   sh;
        logic [IDX_W-1:0]  idx;
        logic [OP_W-1:0]   op;
        logic              op_ok;
        logic              abort;
    } rx_st_t;

    typedef struct packed {
        logic              oe;
        logic [OP_W-1:0]   sr;
    } tx_st_t;

endpackage

// File: rtl/sfe_spi_rx.sv
module sfe_spi_rx
    import sfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             mosi,
    input  logic             pause_n,
    output logic             live,
    output logic             fall_ev,
    output logic             cmd_end,
    output logic             pause_abort,
    output logic [OP_W-1:0]  op,
    output logic             op_ok,
    output logic             on_boundary
);

    rx_st_t q, d;
    logic   rise_ev;

    always_comb begin
        live        = !cs_n && pause_n && !q.abort;
        rise_ev     = live && sck && !q.sck;
        fall_ev     = live && !sck && q.sck;
        cmd_end     = cs_n && q.sel && !q.abort;
        pause_abort = !cs_n && !q.abort && !pause_n;

        d     = q;
        d.sck = sck;
        d.sel = !cs_n;
        if (cs_n) begin
            d.idx   = '0;
            d.op_ok = 1'b0;
            d.abort = 1'b0;
            d.sh    = '0;
        end else if (pause_abort) begin
            d.abort = 1'b1;
        end else if (rise_ev) begin
            d.sh  = {q.sh[OP_W-2:0], mosi};
            d.idx = q.idx + IDX_W'(1);
            if ((q.idx == IDX_W'(OP_W - 1)) && !q.op_ok) begin
                d.op_ok = 1'b1;
                d.op    = {q.sh[OP_W-2:0], mosi};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign op          = q.op;
    assign op_ok       = q.op_ok;
    assign on_boundary = (q.idx == '0);

    // R9: once the opcode is captured it holds for the rest of the transaction
    p_op_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op_ok && $past(q.op_ok)) |-> $stable(q.op));

    // R5: deselect always discards the partial opcode
    p_deselect_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!q.op_ok && !q.abort));

endmodule

// File: rtl/sfe_arm_ctrl.sv
module sfe_arm_ctrl
    import sfe_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_end,
    input  logic             pause_abort,
    input  logic [OP_W-1:0]  op,
    input  logic             op_ok,
    input  logic             on_boundary,
    output logic             armed,
    output logic             busy
);

    localparam int TW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic          armed;
        logic [TW-1:0] tmr;
    } arm_st_t;

    arm_st_t q, d;

    always_comb begin
        busy = (q.tmr != '0);
        d    = q;
        if (busy) begin
            d.tmr = q.tmr - TW'(1);
            if (q.tmr == TW'(1)) d.armed = 1'b0;
        end else if (cmd_end && op_ok) begin
            if (op == OP_ARM) begin
                if (on_boundary) d.armed = 1'b1;
            end else if (op == OP_DISARM) begin
                if (on_boundary) d.armed = 1'b0;
            end else if (is_guarded(op) && q.armed) begin
                if (is_timed(op) && on_boundary) d.tmr   = TW'(BUSY_CYCLES);
                else                             d.armed = 1'b0;
            end
        end else if (pause_abort && op_ok && is_guarded(op)) begin
            d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign armed = q.armed;

    // R2: the latch only rises at the end of an arm command
    p_arm_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.armed && !$past(q.armed)) |-> ($past(cmd_end) && ($past(op) == OP_ARM)));

    // R3: a busy period only starts from an armed state
    p_busy_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.armed));

    // R6: the latch is clear once the busy period ends
    p_expiry_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !q.armed);

    // R5: a short command does not touch the latch
    p_short_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && !op_ok && !busy) |=> $stable(q.armed));

    // R7: nothing sets the latch while busy
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(q.armed && !$past(q.armed)));

endmodule

// File: rtl/sfe_stat_tx.sv
module sfe_stat_tx
    import sfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic             fall_ev,
    input  logic             rd_sel,
    input  logic             on_boundary,
    input  logic [OP_W-1:0]  stat_byte,
    output logic             miso,
    output logic             miso_oe
);

    tx_st_t q, d;

    always_comb begin
        d = q;
        if (!live) begin
            d.oe = 1'b0;
        end else if (fall_ev && rd_sel) begin
            d.oe = 1'b1;
            d.sr = on_boundary ? stat_byte : {q.sr[OP_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miso    = q.sr[OP_W-1];
    assign miso_oe = q.oe;

    // R11 (and R8): MISO is released the cycle after the link goes idle or pauses
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> !q.oe);

    // R9: MISO is only driven under a fully received status-read opcode
    p_drive_rdsr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> rd_sel);

    // R10: a boundary reload captures the pre-edge status
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live && fall_ev && rd_sel && on_boundary) |=> (q.sr == $past(stat_byte)));

endmodule

// File: rtl/sfe_cmd_front.sv
module sfe_cmd_front
    import sfe_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic pause_n,
    output logic miso,
    output logic miso_oe,
    output logic wr_armed,
    output logic busy
);

    logic             live;
    logic             fall_ev;
    logic             cmd_end;
    logic             pause_abort;
    logic [OP_W-1:0]  op;
    logic             op_ok;
    logic             on_boundary;
    logic             rd_sel;
    logic [OP_W-1:0]  stat_byte;

    sfe_spi_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .mosi        (mosi),
        .pause_n     (pause_n),
        .live        (live),
        .fall_ev     (fall_ev),
        .cmd_end     (cmd_end),
        .pause_abort (pause_abort),
        .op          (op),
        .op_ok       (op_ok),
        .on_boundary (on_boundary)
    );

    sfe_arm_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_end     (cmd_end),
        .pause_abort (pause_abort),
        .op          (op),
        .op_ok       (op_ok),
        .on_boundary (on_boundary),
        .armed       (wr_armed),
        .busy        (busy)
    );

    always_comb begin
        rd_sel                 = op_ok && (op == OP_STAT_RD);
        stat_byte              = '0;
        stat_byte[ST_ARM_BIT]  = wr_armed;
        stat_byte[ST_BUSY_BIT] = busy;
    end

    sfe_stat_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .live        (live),
        .fall_ev     (fall_ev),
        .rd_sel      (rd_sel),
        .on_boundary (on_boundary),
        .stat_byte   (stat_byte),
        .miso        (miso),
        .miso_oe     (miso_oe)
    );

endmodule

// File: tb/sfe_cmd_front_tb_top.sv
`timescale 1ns/1ps
module sfe_cmd_front_tb_top;

    localparam int BUSY = 150;
    localparam int H    = 2;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, pause_n = 1'b1;
    logic miso, miso_oe, wr_armed, busy;

    always #5 clk = ~clk;

    sfe_cmd_front #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .pause_n(pause_n), .miso(miso), .miso_oe(miso_oe),
        .wr_armed(wr_armed), .busy(busy)
    );

    int    checks = 0, errors = 0, m_coll = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    bit         m_arm, m_sel, m_sck, m_abort, m_oe, m_so;
    int         m_left, m_bits;
    logic [7:0] m_sh, m_op;
    bit         m_q[$];
    logic [7:0] rdbuf [0:7];

    function automatic bit mf_guard(logic [7:0] o);
        return o == 8'h01 || o == 8'h02 || o == 8'h20 || o == 8'h60 || o == 8'h36 || o == 8'h39;
    endfunction
    function automatic bit mf_timed(logic [7:0] o);
        return o == 8'h02 || o == 8'h20 || o == 8'h60;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit old_arm, old_busy, expired;
        logic [7:0] sb;
        old_arm  = m_arm;
        old_busy = (m_left > 0);
        expired  = 1'b0;
        if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin m_arm = 1'b0; expired = 1'b1; end
        end
        if (cs_n) begin
            if (m_sel && !m_abort && m_bits >= 8 && !old_busy) begin
                if (m_op == 8'h06) begin
                    if (m_bits % 8 == 0) m_arm = 1'b1;
                end else if (m_op == 8'h04) begin
                    if (m_bits % 8 == 0) m_arm = 1'b0;
                end else if (mf_guard(m_op) && old_arm) begin
                    if (mf_timed(m_op) && m_bits % 8 == 0) m_left = BUSY;
                    else m_arm = 1'b0;
                end
            end
            m_sel = 1'b0; m_bits = 0; m_abort = 1'b0; m_oe = 1'b0; m_q.delete();
        end else begin
            m_sel = 1'b1;
            if (!m_abort) begin
                if (!pause_n) begin
                    m_abort = 1'b1; m_oe = 1'b0;
                    if (m_bits >= 8 && mf_guard(m_op) && !old_busy) m_arm = 1'b0;
                end else if (sck && !m_sck) begin
                    m_bits++;
                    m_sh = {m_sh[6:0], mosi};
                    if (m_bits == 8) m_op = m_sh;
                end else if (!sck && m_sck && m_bits >= 8 && m_op == 8'h05) begin
                    if (m_q.size() == 0) begin
                        sb = {6'b0, old_arm, old_busy};
                        for (int b = 7; b >= 0; b--) m_q.push_back(sb[b]);
                        if (expired) m_coll++;
                    end
                    m_so = m_q.pop_front();
                    m_oe = 1'b1;
                end
            end
        end
        m_sck = sck;
    endtask

    task automatic compare();
        check(cur_req, "wr_armed", int'(wr_armed), int'(m_arm));
        check(cur_req, "busy", int'(busy), int'(m_left > 0));
        check(cur_req, "miso_oe", int'(miso_oe), int'(m_oe));
        if (m_oe) check(cur_req, "miso", int'(miso), int'(m_so));
    endtask

    task automatic tick();
        @(posedge clk); #1;
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    task automatic xfer(input logic [7:0] op, input int nbits, input int pause_at);
        cs_n = 1'b0; tick();
        for (int i = 0; i < nbits; i++) begin
            if (i == pause_at) pause_n = 1'b0;
            mosi = (i < 8) ? op[7-i] : 1'b0;
            repeat (H) tick();
            if (i >= 8 && i < 72) rdbuf[(i-8)/8][7-((i-8)%8)] = miso;
            sck = 1'b1; repeat (H) tick(); sck = 1'b0;
        end
        repeat (H) tick();
        cs_n = 1'b1; tick(); tick();
        pause_n = 1'b1; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        cur_req = "R1";
        check("R1", "armed after reset", int'(wr_armed), 0);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "oe after reset", int'(miso_oe), 0);

        cur_req = "R9";
        xfer(8'h05, 24, -1);
        check("R10", "idle status byte0", int'(rdbuf[0]), 8'h00);
        check("R10", "idle status byte1", int'(rdbuf[1]), 8'h00);

        cur_req = "R3";
        xfer(8'h02, 32, -1);
        check("R3", "program unarmed busy", int'(busy), 0);
        xfer(8'h60, 8, -1);
        check("R3", "erase unarmed busy", int'(busy), 0);
        xfer(8'h01, 16, -1);
        check("R3", "status write unarmed", int'(wr_armed), 0);

        cur_req = "R2";
        xfer(8'h06, 8, -1);
        xfer(8'h05, 16, -1);
        check("R2", "status after arm", int'(rdbuf[0]), 8'h02);
        xfer(8'h04, 8, -1);
        xfer(8'h05, 16, -1);
        check("R2", "status after disarm", int'(rdbuf[0]), 8'h00);

        cur_req = "R5";
        xfer(8'h06, 8, -1);
        xfer(8'h02, 5, -1);
        xfer(8'h00, 0, -1);
        xfer(8'h05, 16, -1);
        check("R5", "short commands keep latch", int'(rdbuf[0]), 8'h02);
        cur_req = "R11";
        xfer(8'hAB, 8, -1);
        check("R11", "unknown opcode keeps latch", int'(wr_armed), 1);

        cur_req = "R4";
        xfer(8'h01, 16, -1);
        check("R4", "status write completes", int'(wr_armed), 0);
        xfer(8'h06, 8, -1); xfer(8'h36, 8, -1);
        check("R4", "lock completes", int'(wr_armed), 0);
        xfer(8'h06, 8, -1); xfer(8'h39, 12, -1);
        check("R4", "unlock aborts", int'(wr_armed), 0);
        xfer(8'h06, 8, -1); xfer(8'h02, 13, -1);
        check("R4", "program abort armed", int'(wr_armed), 0);
        check("R4", "program abort busy", int'(busy), 0);

        cur_req = "R6";
        xfer(8'h06, 8, -1); xfer(8'h20, 32, -1);
        check("R6", "busy after erase", int'(busy), 1);
        idle(BUSY - 3);
        check("R6", "busy before last cycle", int'(busy), 1);
        check("R6", "armed during busy", int'(wr_armed), 1);
        idle(1);
        check("R6", "busy after expiry", int'(busy), 0);
        check("R6", "armed after expiry", int'(wr_armed), 0);

        cur_req = "R7";
        xfer(8'h06, 8, -1); xfer(8'h60, 8, -1);
        xfer(8'h05, 16, -1);
        check("R10", "status while busy", int'(rdbuf[0]), 8'h03);
        xfer(8'h04, 8, -1);
        check("R7", "disarm ignored while busy", int'(wr_armed), 1);
        check("R7", "still busy", int'(busy), 1);
        idle(BUSY);
        check("R6", "erase finished", int'(wr_armed), 0);

        cur_req = "R8";
        xfer(8'h06, 8, -1); xfer(8'h02, 16, 10);
        check("R8", "pause after guarded opcode", int'(wr_armed), 0);
        xfer(8'h06, 8, -1); xfer(8'h02, 16, 4);
        check("R8", "pause inside opcode", int'(wr_armed), 1);
        xfer(8'h05, 24, 12);
        check("R8", "pause during status read", int'(wr_armed), 1);
        check("R8", "oe released after pause", int'(miso_oe), 0);

        cur_req = "R10";
        for (int off = 0; off < 32; off++) begin
            xfer(8'h06, 8, -1); xfer(8'h02, 32, -1);
            idle(off);
            xfer(8'h05, 48, -1);
            check("R10", "status after program", int'(rdbuf[4]), 8'h00);
        end
        check("R10", "expiry hit a reload edge", int'(m_coll > 0), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule